// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 262,144 sixteen-bit words. The memory has one shared bidirectional data bus and a separate active-low strobe for each byte lane. The system side presents one request at a time: a word address, a write flag, a byte-enable mask and write data. The request is accepted only while `ready` is high. The controller answers with a single-cycle `done`, and for a read it also returns the captured word in a holding register.

On the memory side the controller drives the 18-bit address, chip select, write enable, output enable and the two lane strobes, all active low, from registers. The data bus is split into an output value, an output enable and an input value, and the pad ring joins them. Every timing window is a whole number of clock cycles. Each is computed at elaboration time from the clock period and the memory's nanosecond limits, rounded up so that every minimum is met.

Output enable stays high for the whole of a write, so the shorter write pulse is legal. After a read, the data drivers stay off until the memory's output hold-off time has passed, so the bus never has two drivers at once.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, chip select, write enable, output enable and both lane strobes are high (inactive), the data driver enable is low, `ready` is 1 and `done` is 0.
- R2: During a write, write enable is low for exactly ceil(max(7 ns, 5 ns)/clock) cycles, which is 2 cycles (8 ns) with a 4 ns clock. For that whole time chip select is low, output enable is high, and the data driver is on with the request's write data.
- R3: Byte-enable bit 0 selects the lower lane, which is strobe bit 0 and data bits 7:0. Bit 1 selects the upper lane, which is strobe bit 1 and data bits 15:8. A write changes only the enabled lanes, and a write with both enables clear leaves the word unchanged. Both strobes are high whenever chip select is high.
- R4: During a read, chip select and output enable are low together for ceil(10 ns/clock) cycles, which is 3 cycles. The bus is captured at the end of that window. In the returned word, the bytes of disabled lanes are zero.
- R5: `done` is high for exactly one cycle per request. It rises 2 clock edges after the accepting edge for a write and 3 edges after it for a read.
- R6: The data driver is never on while output enable is low. After a read, `ready` returns only after ceil(5 ns/clock) cycles with output enable high, which is 2 edges after `done`. The driver turns on at least 5 ns after the memory stops driving.
- R7: A request is accepted only on an edge where `ready` is 1, and `ready` is 1 only when the memory is deselected. A request presented while busy has no effect: it writes nothing, raises no extra `done` and does not drop `ready`.
- R8: Two consecutive write strobes start at least 10 ns apart. This is the minimum write cycle, which the write recovery state guarantees.
- R9: The memory address equals the accepted request address and stays stable for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, sampled while ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Controller idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read word, disabled lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane strobes, active low, bit 0 = lower byte |
| dq_out | output | 16 | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | 16 | Value read from the data bus |

## Verification
The assertions assume that the system side never drops `req` on the accepting edge before that edge is sampled. They also assume that the clock period parameter matches the real clock, so that every window of at least 2 cycles is also long enough in nanoseconds. The stimulus changes request fields only at falling clock edges and starts a new request only once `ready` is seen high. It deliberately holds one request across a busy cycle to show that such a request is ignored. Random addresses fall inside a small window so that lanes are rewritten often, and a few directed cases reach the highest and lowest addresses and the zero-enable write.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WREC,
        ST_RD,
        ST_RREL
    } state_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(val))); // R5
endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane (
    input  logic       act,
    input  logic       en,
    input  logic [7:0] rd_byte,
    output logic       lane_n,
    output logic [7:0] rd_keep
);
    assign lane_n  = !(act && en);
    assign rd_keep = en ? rd_byte : 8'h00;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int CLK_NS  = 4,
    parameter int T_WP_NS = 7,
    parameter int T_DS_NS = 5,
    parameter int T_WC_NS = 10,
    parameter int T_RD_NS = 10,
    parameter int T_OE_NS = 5,
    parameter int T_HZ_NS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_we,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW/8-1:0]    req_be,
    input  logic [DW-1:0]      req_wdata,
    output logic               ready,
    output logic               done,
    output logic [DW-1:0]      rdata,
    output logic [AW-1:0]      sram_addr,
    output logic               sram_ce_n,
    output logic               sram_we_n,
    output logic               sram_oe_n,
    output logic [DW/8-1:0]    sram_be_n,
    output logic [DW-1:0]      dq_out,
    output logic               dq_oe,
    input  logic [DW-1:0]      dq_in
);
    localparam int LANES    = DW / 8;
    localparam int WP_CYC   = imax(1, cdiv(imax(T_WP_NS, T_DS_NS), CLK_NS));
    localparam int REC_CYC  = imax(1, cdiv(T_WC_NS, CLK_NS) - WP_CYC);
    localparam int RD_CYC   = imax(1, cdiv(imax(T_RD_NS, T_OE_NS), CLK_NS));
    localparam int TURN_CYC = imax(1, cdiv(T_HZ_NS, CLK_NS));
    localparam int MAXC     = imax(imax(WP_CYC, REC_CYC), imax(RD_CYC, TURN_CYC));
    localparam int CW       = imax(1, $clog2(MAXC + 1));

    typedef struct packed {
        state_t            st;
        logic [AW-1:0]     addr;
        logic [LANES-1:0]  be;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, addr: '0, be: '0, wdata: '0, rdata: '0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, done: 1'b0
    };

    regs_t         r_d, r_q;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    logic [DW-1:0] rd_merge;

    sram_ctl_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .val   (cnt_val),
        .zero  (cnt_zero)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ctl_lane u_lane (
            .act     (!r_q.ce_n),
            .en      (r_q.be[g]),
            .rd_byte (dq_in[8*g +: 8]),
            .lane_n  (sram_be_n[g]),
            .rd_keep (rd_merge[8*g +: 8])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.be    = req_be;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = 1'b0;
                    cnt_load  = 1'b1;
                    if (req_we) begin
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.st    = ST_WR;
                        cnt_val   = CW'(WP_CYC - 1);
                    end else begin
                        r_d.oe_n  = 1'b0;
                        r_d.st    = ST_RD;
                        cnt_val   = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_WR: begin
                if (cnt_zero) begin
                    r_d.we_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_WREC;
                    cnt_load  = 1'b1;
                    cnt_val   = CW'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (cnt_zero) r_d.st = ST_IDLE;
            end
            ST_RD: begin
                if (cnt_zero) begin
                    r_d.rdata = rd_merge;
                    r_d.oe_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_RREL;
                    cnt_load  = 1'b1;
                    cnt_val   = CW'(TURN_CYC - 1);
                end
            end
            ST_RREL: begin
                if (cnt_zero) r_d.st = ST_IDLE;
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign done      = r_q.done;
    assign rdata     = r_q.rdata;
    assign sram_addr = r_q.addr;
    assign sram_ce_n = r_q.ce_n;
    assign sram_we_n = r_q.we_n;
    assign sram_oe_n = r_q.oe_n;
    assign dq_out    = r_q.wdata;
    assign dq_oe     = r_q.dq_oe;

    AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && dq_oe)); // R2
    AST_LANES_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (&sram_be_n)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_NO_DRIVE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> sram_oe_n); // R6
    AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(sram_oe_n) && $past(sram_oe_n, 2))); // R6
    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !dq_oe)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R9
endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, req_we;
    logic [17:0] req_addr;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic        ready, done;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_be_n;
    logic [15:0] dq_out, dq_in;
    logic        dq_oe;
    logic        drv_now;

    int n_run = 0;
    int n_bad = 0;
    logic [15:0] mem_m [64];
    logic [15:0] ref_m [64];
    logic [17:0] cur_addr;
    logic [15:0] cur_wd;
    realtime t_wf = -1000.0;
    realtime t_of = -1000.0;
    realtime t_off = -1000.0;

    always #2 clk = ~clk;

    sram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .ready(ready), .done(done),
        .rdata(rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [17:0] a, input logic [1:0] be);
        logic [15:0] w = ref_m[a[5:0]];
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    // behavioural memory: lanes not driven read as junk
    always_comb begin
        drv_now = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_be_n != 2'b11);
        dq_in   = 16'h5AA5;
        if (dq_oe) dq_in = dq_out;
        else if (drv_now) begin
            if (!sram_be_n[0]) dq_in[7:0]  = mem_m[sram_addr[5:0]][7:0];
            if (!sram_be_n[1]) dq_in[15:8] = mem_m[sram_addr[5:0]][15:8];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n) begin
            if (!sram_be_n[0]) mem_m[sram_addr[5:0]][7:0]  <= dq_in[7:0];
            if (!sram_be_n[1]) mem_m[sram_addr[5:0]][15:8] <= dq_in[15:8];
        end
        if (rst_n && !sram_we_n)
            chk(sram_oe_n && !sram_ce_n && dq_oe && dq_out == cur_wd, "R2 write bus",
                {15'd0, sram_oe_n, dq_out}, {16'd1, cur_wd});
        if (rst_n && !sram_ce_n)
            chk(sram_addr == cur_addr, "R9 address held", 32'(sram_addr), 32'(cur_addr));
    end

    always @(negedge sram_we_n) if (rst_n) begin
        if (t_wf >= 0.0)
            chk(($realtime - t_wf) >= 10.0, "R8 write spacing ns", int'($realtime - t_wf), 10);
        t_wf = $realtime;
    end
    always @(posedge sram_we_n) if (rst_n && t_wf >= 0.0)
        chk(int'($realtime - t_wf) == 8, "R2 strobe width ns", int'($realtime - t_wf), 8);
    always @(negedge sram_oe_n) if (rst_n) t_of = $realtime;
    always @(posedge sram_oe_n) if (rst_n && t_of >= 0.0)
        chk(int'($realtime - t_of) == 12, "R4 read strobe ns", int'($realtime - t_of), 12);
    always @(negedge drv_now) t_off = $realtime;
    always @(posedge dq_oe) if (rst_n) begin
        chk(!drv_now, "R6 memory still driving", 32'(drv_now), 0);
        chk(($realtime - t_off) >= 5.0, "R6 hold-off ns", int'($realtime - t_off), 5);
    end

    task automatic do_op(input logic [17:0] a, input bit w, input logic [1:0] be,
                         input logic [15:0] wd, input bit spur);
        int lat;
        logic [15:0] e;
        @(negedge clk);
        chk(ready, "R7 ready before request", 32'(ready), 1);
        req = 1'b1; req_we = w; req_addr = a; req_be = be; req_wdata = wd;
        cur_addr = a; cur_wd = wd;
        e = exp_rd(a, be);
        if (w) begin
            if (be[0]) ref_m[a[5:0]][7:0]  = wd[7:0];
            if (be[1]) ref_m[a[5:0]][15:8] = wd[15:8];
        end
        @(posedge clk);
        @(negedge clk);
        if (spur) begin
            req_addr = a ^ 18'h11; req_we = 1'b1; req_be = 2'b11; req_wdata = 16'hDEAD;
            chk(!ready, "R7 busy after accept", 32'(ready), 0);
        end else req = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk); lat++;
            @(negedge clk); req = 1'b0;
        end
        chk(lat == (w ? 2 : 3), "R5 done latency", 32'(lat), w ? 2 : 3);
        if (!w) chk(rdata == e, "R4 read data", 32'(rdata), 32'(e));
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R5 single-cycle done", 32'(done), 0);
        chk(ready == w, "R6 ready after release", 32'(ready), 32'(w));
        while (!ready) @(negedge clk);
        if (spur) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(ready && !done, "R7 busy request ignored", {ready, done}, 2'b10);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_run++; n_bad++;
        $display("FAIL R5 watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [17:0] a;
        for (int i = 0; i < 64; i++) begin mem_m[i] = 16'h0; ref_m[i] = 16'h0; end
        rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
        cur_addr = '0; cur_wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_be_n} == 5'b11111, "R1 strobes idle",
            32'({sram_ce_n, sram_we_n, sram_oe_n, sram_be_n}), 32'h1f);
        chk(!dq_oe && ready && !done, "R1 driver off ready", {dq_oe, ready, done}, 3'b010);
        rst_n = 1'b1;

        do_op(18'h00000, 1, 2'b11, 16'h1357, 0);
        do_op(18'h00000, 0, 2'b11, 16'h0, 0);                  // R4
        do_op(18'h3FFFF, 1, 2'b11, 16'hBEEF, 0);
        do_op(18'h3FFFF, 0, 2'b11, 16'h0, 0);
        do_op(18'h00005, 1, 2'b11, 16'h1234, 0);
        do_op(18'h00005, 1, 2'b01, 16'hABCD, 0);               // R3 lower only
        do_op(18'h00005, 0, 2'b11, 16'h0, 0);
        do_op(18'h00005, 1, 2'b10, 16'h9876, 0);               // R3 upper only
        do_op(18'h00005, 0, 2'b01, 16'h0, 0);                  // R4 disabled lane zero
        do_op(18'h00005, 0, 2'b10, 16'h0, 0);
        do_op(18'h00005, 1, 2'b00, 16'hFFFF, 0);               // R3 no lane
        do_op(18'h00005, 0, 2'b11, 16'h0, 0);
        do_op(18'h00020, 1, 2'b11, 16'hC0DE, 1);               // R7 spurious while busy
        do_op(18'h00020 ^ 18'h11, 0, 2'b11, 16'h0, 0);
        do_op(18'h00007, 0, 2'b11, 16'h0, 1);
        do_op(18'h00007 ^ 18'h11, 0, 2'b11, 16'h0, 0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 300; i++) begin
            a = 18'($urandom_range(0, 31));
            if (($urandom & 32'h7) == 0) a = a | 18'h3FFC0;
            do_op(a, 1'($urandom), 2'($urandom), 16'($urandom), (($urandom & 32'hF) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule